// File: doc/BRIEF.md
# Reload-Compare Programmable Clock Divider Core

This block divides its input clock by a programmable integer between 1 and 511. A synchronous down counter starts from all ones and steps down by one on every rising clock edge. When the counter would reach the bitwise complement of the active divisor, it jumps back to all ones instead, and a one-cycle reload strobe is raised. The strobe is the raw divided clock: a narrow pulse once per output period, exactly divisor cycles apart. The block also exports the live counter value so that a duty-cycle stage beside it can place a mid-period edge.

The divisor input is sampled at reload time only. A new value therefore applies from the next output period, and no period is ever cut short. A divisor of zero is illegal. The block then parks: the counter stays at all ones, the strobe stays low, and the divisor input is watched on every cycle until a legal value arrives. The first sample after reset is taken on the first active clock edge.

Top module: `clkdiv_reload_top`

## Requirements
- R1: While reset is asserted, and on the first edge after its release, `count_o` is all ones and `reload_o` is low.
- R2: With a legal divisor active, `count_o` decreases by exactly one per clock cycle, starting from all ones, until a reload occurs.
- R3: A reload takes place at the clock edge where the counter would take the value equal to the bitwise complement of the active divisor. At that edge `count_o` returns to all ones and `reload_o` goes high for exactly that one cycle. Reload pulses are spaced exactly divisor cycles apart.
- R4: The divisor is sampled on the first clock edge after reset release. The first reload pulse appears divisor cycles after that edge: counting the first edge after release as edge 1, `reload_o` goes high after edge divisor+1.
- R5: A divisor of 1 makes `reload_o` stay high on every cycle from the first reload onward, with `count_o` held at all ones.
- R6: A divisor of 0 is illegal and holds the block idle: `reload_o` stays low and `count_o` stays all ones. A legal divisor applied while idle is taken on the next edge, and the first pulse follows divisor cycles later.
- R7: A change on `div_i` takes effect only at the next reload. The period in progress completes with the old divisor.
- R8: The largest divisor, 511 (all ones), gives a period of 511 cycles, with the counter reaching 1 just before the reload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock to be divided; rising edge active |
| rst_ni | input | 1 | Synchronous active-low reset |
| div_i | input | DIV_W | Requested divisor, 0 illegal |
| reload_o | output | 1 | Reload strobe, one cycle wide, once per output period |
| count_o | output | DIV_W | Current down-counter value |

## Verification
The bench builds the block with its default 9-bit divisor width. At this width every divisor from 1 to 40 can be swept completely over two full periods each. The top of the range (63, 64, 255, 256, 263, 510, 511) is reached as well, which covers the counter wrapping through all of its bits. The same width also lets the bench cover entering and leaving the illegal zero divisor, and a divisor change in mid-period, within a short run.

// File: rtl/clkdiv_reload_pkg.sv
// Package: shared constants for the reload-compare divider.
// Assumes: consumers size their counters from DIV_W_DEF unless overridden.
package clkdiv_reload_pkg;
    parameter int unsigned DIV_W_DEF = 9;
endpackage

// File: rtl/clkdiv_div_hold.sv
// Module: holds the active divisor.
// Samples div_i when the block is idle (active divisor zero) or at a reload,
// so a divisor change never truncates the period in progress.
// Assumes: synchronous active-low reset; reload_now comes from the matcher.
module clkdiv_div_hold #(
    parameter int unsigned DIV_W = 9
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [DIV_W-1:0] div_i,
    input  logic             reload_now,
    output logic [DIV_W-1:0] div_q,
    output logic             idle
);
    // Idle whenever no legal divisor is held.
    always_comb begin
        idle = (div_q == '0);
    end

    // Sample the requested divisor at reload or while idle.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            div_q <= '0;
        end else if (idle || reload_now) begin
            div_q <= div_i;
        end
    end
endmodule

// File: rtl/clkdiv_match.sv
// Module: terminal-count detector.
// Flags a reload when the counter's next value equals the complement of the
// active divisor. Assumes: idle is high when the divisor is zero.
module clkdiv_match #(
    parameter int unsigned DIV_W = 9
) (
    input  logic [DIV_W-1:0] cnt_q,
    input  logic [DIV_W-1:0] div_q,
    input  logic             idle,
    output logic             reload_now
);
    logic [DIV_W-1:0] cnt_dec;

    // Compare the decremented count against the complemented divisor.
    always_comb begin
        cnt_dec    = cnt_q - {{(DIV_W-1){1'b0}}, 1'b1};
        reload_now = !idle && (cnt_dec == ~div_q);
    end
endmodule

// File: rtl/clkdiv_counter.sv
// Module: down counter and registered reload strobe.
// Counts down from all ones, returns to all ones on reload, and parks at all
// ones while idle. Assumes: reload_now and idle are combinational inputs.
module clkdiv_counter #(
    parameter int unsigned DIV_W = 9
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             reload_now,
    input  logic             idle,
    output logic [DIV_W-1:0] cnt_q,
    output logic             pulse_q
);
    localparam logic [DIV_W-1:0] ALL_ONES = '1;

    // Advance, reload or park the counter.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= ALL_ONES;
        end else if (idle || reload_now) begin
            cnt_q <= ALL_ONES;
        end else begin
            cnt_q <= cnt_q - {{(DIV_W-1){1'b0}}, 1'b1};
        end
    end

    // Register the reload strobe so the output is glitch free.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= reload_now;
        end
    end
endmodule

// File: rtl/clkdiv_reload_top.sv
// Module: reload-compare programmable clock divider, top level.
// Divides clk_i by div_i (1..2^DIV_W-1); reload_o pulses once per period and
// count_o exposes the counter for a duty-cycle stage. Assumes: div_i is
// synchronous to clk_i; a divisor of zero holds the block idle.
module clkdiv_reload_top #(
    parameter int unsigned DIV_W = clkdiv_reload_pkg::DIV_W_DEF
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [DIV_W-1:0] div_i,
    output logic             reload_o,
    output logic [DIV_W-1:0] count_o
);
    logic [DIV_W-1:0] div_hold;
    logic             idle;
    logic             reload_now;
    logic [DIV_W-1:0] cnt_q;
    logic             pulse_q;

    clkdiv_div_hold #(.DIV_W(DIV_W)) u_hold (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .div_i      (div_i),
        .reload_now (reload_now),
        .div_q      (div_hold),
        .idle       (idle)
    );

    clkdiv_match #(.DIV_W(DIV_W)) u_match (
        .cnt_q      (cnt_q),
        .div_q      (div_hold),
        .idle       (idle),
        .reload_now (reload_now)
    );

    clkdiv_counter #(.DIV_W(DIV_W)) u_cnt (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .reload_now (reload_now),
        .idle       (idle),
        .cnt_q      (cnt_q),
        .pulse_q    (pulse_q)
    );

    // Drive the outputs from the registered state.
    always_comb begin
        reload_o = pulse_q;
        count_o  = cnt_q;
    end
endmodule

// File: rtl/clkdiv_reload_chk.sv
// Module: property checker for clkdiv_reload_top, attached by bind.
// Observes the ports and the held divisor.
module clkdiv_reload_chk #(
    parameter int unsigned DIV_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pulse,
    input logic [DIV_W-1:0] cnt,
    input logic [DIV_W-1:0] div_act
);
    localparam logic [DIV_W-1:0] ONES = '1;

    // R2: a non-reload, non-start cycle is one below the previous count.
    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !pulse && cnt != ONES) |-> (cnt == $past(cnt) - 1'b1));

    // R3: a reload pulse always coincides with the counter at all ones.
    assert_reload_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> (cnt == ONES));

    // R6: held idle across two cycles means no pulse and a parked counter.
    assert_idle_park_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && div_act == '0 && $past(div_act) == '0) |-> (!pulse && cnt == ONES));

    // R7: a held legal divisor only changes on a reload edge.
    assert_div_at_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(div_act) != '0 && div_act != $past(div_act)) |-> pulse);
endmodule

bind clkdiv_reload_top clkdiv_reload_chk #(.DIV_W(DIV_W)) u_chk (
    .clk     (clk_i),
    .rst_n   (rst_ni),
    .pulse   (reload_o),
    .cnt     (count_o),
    .div_act (div_hold)
);

// File: tb/clkdiv_reload_top_tb_top.sv
// Bench: sweeps divisors and checks pulse spacing and count values arithmetically.
module clkdiv_reload_top_tb_top;
    localparam int W    = 9;
    localparam int ONES = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] div = '0;
    logic         reload;
    logic [W-1:0] count;

    int total = 0;
    int bad = 0;

    clkdiv_reload_top #(.DIV_W(W)) dut_i (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .div_i    (div),
        .reload_o (reload),
        .count_o  (count)
    );

    // 250 MHz clock.
    always #2 clk = ~clk;

    // Compare one value and report a mismatch.
    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Reset with div_i preset, release at a falling edge.
    task automatic do_reset(input int d);
        @(negedge clk);
        rst_n = 1'b0;
        div   = W'(d);
        @(posedge clk);
        @(negedge clk);
        chk("R1 count in reset", int'(count), ONES);
        chk("R1 reload in reset", int'(reload), 0);
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Step one edge and sample at the following falling edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Run divisor d for n edges after reset; check the closed-form pattern.
    task automatic run_div(input int d, input int n, input string req);
        do_reset(d);
        for (int t = 1; t <= n; t++) begin
            step();
            if (t == 1) begin
                chk("R1 first edge count", int'(count), ONES);
                chk("R1 first edge reload", int'(reload), 0);
            end else begin
                chk(req, int'(count), ONES - ((t - 1) % d));
                chk(req, int'(reload), ((t - 1) % d == 0) ? 1 : 0);
            end
        end
    endtask

    initial begin
        // R2 R3 R4: exhaustive low range, two periods each.
        for (int d = 1; d <= 40; d++) begin
            run_div(d, 2 * d + 3, (d == 1) ? "R5 divide by one" : "R3 period sweep");
        end
        // R3: upper range values.
        run_div(63, 130, "R3 d63");
        run_div(64, 132, "R3 d64");
        run_div(255, 514, "R3 d255");
        run_div(256, 516, "R3 d256");
        run_div(263, 530, "R3 d263");
        run_div(510, 1024, "R3 d510");
        // R8: full-scale divisor; counter reaches 1 before reload.
        run_div(511, 1026, "R8 d511");

        // R6: divisor zero parks the block.
        do_reset(0);
        for (int t = 1; t <= 20; t++) begin
            step();
            chk("R6 idle count", int'(count), ONES);
            chk("R6 idle reload", int'(reload), 0);
        end
        // R6: a legal divisor leaves idle on the next edge.
        div = W'(4);
        for (int t = 1; t <= 13; t++) begin
            step();
            chk("R6 exit idle count", int'(count), ONES - ((t - 1) % 4));
            chk("R6 exit idle reload", int'(reload), (t > 1 && (t - 1) % 4 == 0) ? 1 : 0);
        end

        // R7: change from 5 to 3 in mid-period.
        do_reset(5);
        step(); step(); step();
        div = W'(3);
        step(); step();
        chk("R7 old period count t5", int'(count), ONES - 4);
        chk("R7 no early reload", int'(reload), 0);
        step();
        chk("R7 reload at old period", int'(reload), 1);
        step(); step();
        chk("R7 new divisor count", int'(count), ONES - 2);
        step();
        chk("R7 reload with new divisor", int'(reload), 1);

        // R6 R7: switching to zero finishes the period, then parks.
        div = W'(0);
        step(); step();
        chk("R6 last period count", int'(count), ONES - 2);
        step();
        chk("R6 final reload", int'(reload), 1);
        for (int t = 1; t <= 8; t++) begin
            step();
            chk("R6 parked reload", int'(reload), 0);
            chk("R6 parked count", int'(count), ONES);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule